// File: doc/BRIEF.md
# Cartridge Memory Banking Controller

This controller sits on the expansion-port bus of an 8-bit host. It places a large flash device and a RAM into seven fixed host windows: a low RAM area, two I/O areas and four 8 KB blocks. Each window has its own 2-bit mode and its own 16-bit bank number. For every bus access the controller picks the selected window, applies its mode to choose which memory is enabled, and supplies the bank number as the high address lines of that memory.

Software configures the windows through sixteen byte registers in the last 16 bytes of the third window (the second I/O area). One control byte can hide the register file until the next hardware reset, so a loaded program can use the whole window as memory. The same byte can start a timed soft-reset pulse to the host. That pulse does not alter the banking setup.

The bus is sampled on a fast system clock. Chip enables follow the bus combinationally while phi2 is high. Register writes take effect on the falling edge of phi2.

Top module: `cart_bank_ctrl_top`

## Requirements
- R1: After hardware reset (rstN low), the 8 KB block at select index 6 is in flash mode with bank 0. Every other window is absent, all banks are 0, and the registers are visible. Offset 0 reads 0x00 and offset 1 reads 0x40. softResetN is high.
- R2: A window in mode 00 asserts no chip enable and no write enable. highAddr is 0.
- R3: A window in mode 01 asserts flashCeN low on both reads and writes. highAddr equals the full 16-bit bank of that window, and ramWeN stays high.
- R4: A window in mode 10 asserts ramCeN low. On a write cycle (rwN low) it also asserts ramWeN low.
- R5: A window in mode 11 asserts ramCeN low, but ramWeN stays high even on write cycles.
- R6: When RAM is enabled, highAddr carries only the low RAM_BANK_W (8) bits of the bank, and the bits above them are 0.
- R7: Register map. Offset 0 holds the modes in bits 1:0 for window 0 (low RAM), bits 3:2 for window 1 and bits 5:4 for window 2 (second I/O area), the hide bit in bit 6 and soft reset in bit 7. Offset 1 holds the modes for windows 3, 4, 5 and 6 in bits 1:0, 3:2, 5:4 and 7:6. Offsets 2..15 are bank byte pairs, low byte at the even offset, for windows 0..6 in order. Every register reads back what was written.
- R8: The registers are decoded at window-2 addresses whose bits 9:4 are all ones, and they take precedence over that window's memory mapping. During a register access no chip enable is asserted. A register read drives regDataOe high with the register value.
- R9: Writing 1 to the hide bit makes the registers vanish until the next hardware reset. Reads no longer drive regDataOe, register writes are ignored, and those addresses map as ordinary window-2 memory.
- R10: Writing 1 to the soft-reset bit drives softResetN low for exactly 16 phi2 cycles after the write cycle. Bit 7 reads 1 during the pulse and 0 afterwards. All modes and banks are kept.
- R11: While phi2 is low, no chip enable and no write enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Hardware reset, active low |
| phi2 | input | 1 | Host bus phase clock, high during data phase |
| rwN | input | 1 | Host bus direction, 1 read, 0 write |
| addr | input | 13 | Host address offset within the selected window |
| dataIn | input | 8 | Host write data |
| windowSel | input | 7 | Window select strobes, one-hot, index 0 low RAM, 1..2 I/O areas, 3..6 blocks |
| flashCeN | output | 1 | Flash chip enable, active low |
| ramCeN | output | 1 | RAM chip enable, active low |
| ramWeN | output | 1 | RAM write enable, active low |
| highAddr | output | 16 | High address lines from the bank register |
| regData | output | 8 | Register read data |
| regDataOe | output | 1 | Drive enable for regData onto the host bus |
| softResetN | output | 1 | Reset request to the host, active low |

## Verification
The hardest conditions to reach are the two that persist across many bus cycles. One is the soft-reset pulse, whose length has to be counted in phi2 cycles, not in system clocks. The other is the hidden state, which only a hardware reset can leave. The stimulus starts a pulse, reads the control byte while the pulse is active, and then runs idle phi2 cycles up to and one past the expected end. Next it sets the hide bit while the second I/O area is in flash mode. It then reads and writes the former register addresses, where it expects flash enables. A later block access shows that the ignored write changed nothing. A final hardware reset makes the register file visible again.

// File: rtl/cart_bank_pkg.sv
`timescale 1ns/1ps
package cart_bank_pkg;
  localparam int NUM_WIN = 7;
  localparam int WIN_IO3 = 2;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_ROM = 2'b01,
    MODE_RW  = 2'b10,
    MODE_RO  = 2'b11
  } winMode_e;

  // strobes from bus control into the register/decode datapath
  typedef struct packed {
    logic       hit;        // current access targets the register file
    logic       wr;         // one-clock register write pulse
    logic [3:0] off;        // register offset
    logic [7:0] data;       // write data
    logic       hidden;     // register file hidden
    logic       softActive; // soft reset pulse running
  } ctrlStrobe_t;
endpackage

// File: rtl/cart_bank_ctrl.sv
`timescale 1ns/1ps
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int IO_W      = 10,
  parameter int PULSE_CYC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              phi2,
  input  logic              rwN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              io3Sel,
  input  logic [7:0]        dataIn,
  output ctrlStrobe_t       strobe,
  output logic              softResetN
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic             phi2Q;
  logic             fallEdge;
  logic             hidden;
  logic             regHit;
  logic             regWr;
  logic             cfgWr;
  logic [CNT_W-1:0] pulseCnt;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) phi2Q <= 1'b0;
    else       phi2Q <= phi2;

  assign fallEdge = phi2Q & ~phi2;
  assign regHit   = io3Sel & ~hidden & (&addr[IO_W-1:4]);
  assign regWr    = regHit & ~rwN & fallEdge;
  assign cfgWr    = regWr & (addr[3:0] == 4'd0);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                      hidden <= 1'b0;
    else if (cfgWr && dataIn[6])    hidden <= 1'b1;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                        pulseCnt <= '0;
    else if (cfgWr && dataIn[7])      pulseCnt <= CNT_W'(PULSE_CYC);
    else if (fallEdge && pulseCnt != '0) pulseCnt <= pulseCnt - 1'b1;

  assign softResetN = (pulseCnt == '0);

  always_comb begin
    strobe.hit        = regHit;
    strobe.wr         = regWr;
    strobe.off        = addr[3:0];
    strobe.data       = dataIn;
    strobe.hidden     = hidden;
    strobe.softActive = ~softResetN;
  end

  AST_HIDE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    hidden |=> hidden) else $error("hide bit cleared without reset"); // R9
  AST_HIDDEN_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    hidden |-> !strobe.hit) else $error("register hit while hidden"); // R9
  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rstN)
    $fell(softResetN) |-> pulseCnt == CNT_W'(PULSE_CYC)) else $error("pulse started short"); // R10
  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!softResetN && !fallEdge && !cfgWr) |=> !softResetN) else $error("pulse ended off a phi2 edge"); // R10
endmodule

// File: rtl/cart_bank_regs.sv
`timescale 1ns/1ps
module cart_bank_regs
  import cart_bank_pkg::*;
#(
  parameter int BANK_W     = 16,
  parameter int RAM_BANK_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               phi2,
  input  logic               rwN,
  input  logic [NUM_WIN-1:0] windowSel,
  input  ctrlStrobe_t        strobe,
  output logic               flashCeN,
  output logic               ramCeN,
  output logic               ramWeN,
  output logic [BANK_W-1:0]  highAddr,
  output logic [7:0]         regData,
  output logic               regDataOe
);
  winMode_e          modes [NUM_WIN];
  logic [BANK_W-1:0] banks [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [3:0] MODE_REG  = (w < 3) ? 4'd0 : 4'd1;
    localparam int         MODE_LSB  = (w < 3) ? 2 * w : 2 * (w - 3);
    localparam logic [2:0] BANK_SLOT = 3'(w + 1);

    always_ff @(posedge clk or negedge rstN)
      if (!rstN) begin
        modes[w] <= (w == NUM_WIN - 1) ? MODE_ROM : MODE_OFF;
        banks[w] <= '0;
      end else if (strobe.wr) begin
        if (strobe.off == MODE_REG)
          modes[w] <= winMode_e'(strobe.data[MODE_LSB +: 2]);
        if (strobe.off[3:1] == BANK_SLOT) begin
          if (strobe.off[0]) banks[w][BANK_W-1:8] <= strobe.data;
          else               banks[w][7:0]        <= strobe.data;
        end
      end
  end

  // register readback
  always_comb begin
    regData = 8'h00;
    case (strobe.off)
      4'd0: regData = {strobe.softActive, strobe.hidden, modes[2], modes[1], modes[0]};
      4'd1: regData = {modes[6], modes[5], modes[4], modes[3]};
      default:
        for (int w = 0; w < NUM_WIN; w++)
          if (strobe.off[3:1] == 3'(w + 1))
            regData = strobe.off[0] ? banks[w][BANK_W-1:8] : banks[w][7:0];
    endcase
  end
  assign regDataOe = phi2 & strobe.hit & rwN;

  // window select: lowest index wins
  winMode_e          selMode;
  logic [BANK_W-1:0] selBank;
  logic              selValid;
  always_comb begin
    selMode  = MODE_OFF;
    selBank  = '0;
    selValid = 1'b0;
    for (int w = NUM_WIN - 1; w >= 0; w--)
      if (windowSel[w]) begin
        selMode  = modes[w];
        selBank  = banks[w];
        selValid = 1'b1;
      end
  end

  logic act, romAct, ramAct;
  assign act    = phi2 & selValid & ~strobe.hit;
  assign romAct = act & (selMode == MODE_ROM);
  assign ramAct = act & selMode[1];

  assign flashCeN = ~romAct;
  assign ramCeN   = ~ramAct;
  assign ramWeN   = ~(ramAct & (selMode == MODE_RW) & ~rwN);

  always_comb begin
    if (ramAct)      highAddr = {{(BANK_W - RAM_BANK_W){1'b0}}, selBank[RAM_BANK_W-1:0]};
    else if (romAct) highAddr = selBank;
    else             highAddr = '0;
  end

  AST_CE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(!flashCeN && !ramCeN)) else $error("both chips enabled"); // R3
  AST_WE_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !ramWeN |-> (!rwN && !ramCeN)) else $error("write enable without write"); // R4
  AST_REG_NO_CE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hit |-> (flashCeN && ramCeN && ramWeN)) else $error("memory enabled on register access"); // R8
  AST_PHI_LOW_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !phi2 |-> (flashCeN && ramCeN && ramWeN)) else $error("enable during phi2 low"); // R11
  AST_RAM_MASK: assert property (@(posedge clk) disable iff (!rstN)
    !ramCeN |-> (highAddr >> RAM_BANK_W) == '0) else $error("unmasked RAM bank bits"); // R6
endmodule

// File: rtl/cart_bank_ctrl_top.sv
`timescale 1ns/1ps
module cart_bank_ctrl_top
  import cart_bank_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int IO_W       = 10,
  parameter int BANK_W     = 16,
  parameter int RAM_BANK_W = 8,
  parameter int PULSE_CYC  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               phi2,
  input  logic               rwN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [7:0]         dataIn,
  input  logic [NUM_WIN-1:0] windowSel,
  output logic               flashCeN,
  output logic               ramCeN,
  output logic               ramWeN,
  output logic [BANK_W-1:0]  highAddr,
  output logic [7:0]         regData,
  output logic               regDataOe,
  output logic               softResetN
);
  ctrlStrobe_t strobe;

  cart_bank_ctrl #(.ADDR_W(ADDR_W), .IO_W(IO_W), .PULSE_CYC(PULSE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .phi2(phi2), .rwN(rwN), .addr(addr),
    .io3Sel(windowSel[WIN_IO3]), .dataIn(dataIn),
    .strobe(strobe), .softResetN(softResetN)
  );

  cart_bank_regs #(.BANK_W(BANK_W), .RAM_BANK_W(RAM_BANK_W)) u_regs (
    .clk(clk), .rstN(rstN), .phi2(phi2), .rwN(rwN), .windowSel(windowSel),
    .strobe(strobe), .flashCeN(flashCeN), .ramCeN(ramCeN), .ramWeN(ramWeN),
    .highAddr(highAddr), .regData(regData), .regDataOe(regDataOe)
  );
endmodule

// File: tb/cart_bank_ctrl_top_tb.sv
`timescale 1ns/1ps
module cart_bank_ctrl_top_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic        phi2 = 0;
  logic        rwN = 1;
  logic [12:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic [6:0]  windowSel = '0;
  logic        flashCeN, ramCeN, ramWeN, regDataOe, softResetN;
  logic [15:0] highAddr;
  logic [7:0]  regData;

  always #10 clk = ~clk; // 50 MHz

  cart_bank_ctrl_top u_dut (
    .clk(clk), .rstN(rstN), .phi2(phi2), .rwN(rwN), .addr(addr), .dataIn(dataIn),
    .windowSel(windowSel), .flashCeN(flashCeN), .ramCeN(ramCeN), .ramWeN(ramWeN),
    .highAddr(highAddr), .regData(regData), .regDataOe(regDataOe), .softResetN(softResetN)
  );

  typedef struct {
    logic        fce, rce, rwe;
    logic [15:0] ha;
    logic        oe;
    logic [7:0]  rd;
    logic        softN;
    string       req;
  } exp_t;

  exp_t q[$];
  event sampleEv;
  int   compared = 0;
  int   mismatched = 0;
  bit   done = 0;
  logic expSoft = 1'b1;

  localparam logic [6:0] W_RAM = 7'b0000001, W_IO2 = 7'b0000010, W_IO3 = 7'b0000100,
                         W_B1 = 7'b0001000, W_B2 = 7'b0010000, W_B3 = 7'b0100000,
                         W_B5 = 7'b1000000;

  function automatic exp_t mk(logic fce, logic rce, logic rwe, logic [15:0] ha,
                              logic oe, logic [7:0] rd, logic softN, string req);
    exp_t e;
    e.fce = fce; e.rce = rce; e.rwe = rwe; e.ha = ha;
    e.oe = oe; e.rd = rd; e.softN = softN; e.req = req;
    return e;
  endfunction

  // monitor: pop and compare
  initial forever begin
    exp_t e;
    @(sampleEv);
    #1;
    e = q.pop_front();
    compared++;
    if (flashCeN !== e.fce || ramCeN !== e.rce || ramWeN !== e.rwe || highAddr !== e.ha ||
        regDataOe !== e.oe || softResetN !== e.softN || (e.oe && regData !== e.rd)) begin
      mismatched++;
      $display("FAIL %s: got fce=%b rce=%b rwe=%b ha=%h oe=%b rd=%h softN=%b, expected fce=%b rce=%b rwe=%b ha=%h oe=%b rd=%h softN=%b",
               e.req, flashCeN, ramCeN, ramWeN, highAddr, regDataOe, regData, softResetN,
               e.fce, e.rce, e.rwe, e.ha, e.oe, e.rd, e.softN);
    end
  end

  task automatic busCycle(input logic [6:0] sel, input logic rw, input logic [12:0] a,
                          input logic [7:0] d, input exp_t e);
    @(negedge clk);
    windowSel = sel; rwN = rw; addr = a; dataIn = d;
    @(negedge clk); phi2 = 1;
    repeat (2) @(negedge clk);
    q.push_back(e);
    ->sampleEv;
    @(negedge clk); phi2 = 0;
    repeat (2) @(negedge clk);
    windowSel = '0; rwN = 1;
  endtask

  task automatic regWrite(input logic [3:0] off, input logic [7:0] d, input string req);
    busCycle(W_IO3, 1'b0, 13'h3F0 | 13'(off), d, mk(1, 1, 1, 16'h0, 0, 8'h0, expSoft, req));
  endtask

  task automatic regRead(input logic [3:0] off, input logic [7:0] exp, input string req);
    busCycle(W_IO3, 1'b1, 13'h3F0 | 13'(off), 8'h0, mk(1, 1, 1, 16'h0, 1, exp, expSoft, req));
  endtask

  task automatic mem(input logic [6:0] sel, input logic rw, input logic [12:0] a,
                     input logic fce, input logic rce, input logic rwe,
                     input logic [15:0] ha, input string req);
    busCycle(sel, rw, a, 8'h5A, mk(fce, rce, rwe, ha, 0, 8'h0, expSoft, req));
  endtask

  task automatic idle(input string req);
    busCycle(7'b0, 1'b1, 13'h0, 8'h0, mk(1, 1, 1, 16'h0, 0, 8'h0, expSoft, req));
  endtask

  task automatic lowCheck(input logic [6:0] sel);
    @(negedge clk);
    windowSel = sel; rwN = 0;
    repeat (2) @(negedge clk);
    q.push_back(mk(1, 1, 1, 16'h0, 0, 8'h0, expSoft, "R11"));
    ->sampleEv;
    @(negedge clk);
    windowSel = '0; rwN = 1;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    idle("R1");
    mem(W_B5, 1, 13'h100, 0, 1, 1, 16'h0000, "R1");
    mem(W_B1, 1, 13'h100, 1, 1, 1, 16'h0000, "R1 R2");
    regRead(0, 8'h00, "R1");
    regRead(1, 8'h40, "R1");

    // R7 configure blocks: B1 ROM, B2 RW, B3 RO, B5 ROM
    regWrite(1, 8'h79, "R7");
    regWrite(8, 8'h34, "R7");
    regWrite(9, 8'h12, "R7");
    regWrite(10, 8'hCD, "R7");
    regWrite(11, 8'hAB, "R7");
    regWrite(12, 8'h55, "R7");
    regWrite(13, 8'h66, "R7");
    regRead(9, 8'h12, "R7");
    regRead(1, 8'h79, "R7");
    regRead(10, 8'hCD, "R7");

    mem(W_B1, 1, 13'h0AA, 0, 1, 1, 16'h1234, "R3");
    mem(W_B1, 0, 13'h0AA, 0, 1, 1, 16'h1234, "R3");
    mem(W_B2, 1, 13'h001, 1, 0, 1, 16'h00CD, "R4 R6");
    mem(W_B2, 0, 13'h001, 1, 0, 0, 16'h00CD, "R4 R6");
    mem(W_B3, 0, 13'h002, 1, 0, 1, 16'h0055, "R5");
    mem(W_B3, 1, 13'h002, 1, 0, 1, 16'h0055, "R5");

    // window 0 RW, window 1 off, window 2 ROM
    regWrite(0, 8'h12, "R7");
    regWrite(6, 8'h07, "R7");
    mem(W_IO3, 1, 13'h010, 0, 1, 1, 16'h0007, "R3");
    regRead(6, 8'h07, "R8");
    mem(W_RAM, 0, 13'h020, 1, 0, 0, 16'h0000, "R4");
    mem(W_IO2, 0, 13'h020, 1, 1, 1, 16'h0000, "R2");
    lowCheck(W_RAM);
    lowCheck(W_B1);

    // R10 soft reset pulse
    regWrite(0, 8'h92, "R10");
    expSoft = 0;
    regRead(0, 8'h92, "R10");
    for (int k = 2; k <= 16; k++) idle("R10");
    expSoft = 1;
    idle("R10");
    regRead(0, 8'h12, "R10");
    mem(W_B1, 1, 13'h0AA, 0, 1, 1, 16'h1234, "R10");

    // R9 hide
    regWrite(0, 8'h52, "R9");
    mem(W_IO3, 1, 13'h3F1, 0, 1, 1, 16'h0007, "R9");
    mem(W_IO3, 0, 13'h3F1, 0, 1, 1, 16'h0007, "R9");
    mem(W_B1, 1, 13'h0AA, 0, 1, 1, 16'h1234, "R9");

    // hardware reset restores visibility and defaults
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    regRead(0, 8'h00, "R1 R9");
    regRead(1, 8'h40, "R1");
    mem(W_B1, 1, 13'h0AA, 1, 1, 1, 16'h0000, "R1");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule